// File: doc/BRIEF.md
# Descriptor-Steered Configuration Item DMA Engine

This engine moves bytes of one configuration item into system memory under the control of a descriptor that software places in memory. A start pulse gives the 64-bit address of the descriptor. The engine reads the 16 descriptor bytes, decodes them, and then works through the requested length in one of two ways. In read mode it writes item bytes to the target address. In skip mode it only moves the item cursor forward. When it is done, it writes a 32-bit status word back over the descriptor's first word.

The engine keeps a cursor for the item. The cursor holds a 16-bit key and a byte offset. The offset is kept from one transfer to the next, so a large item can be consumed in pieces. The key's top bit chooses one of two item banks, and the remaining bits give the index within that bank. Positions that lie beyond the end of the item, and reads from an item that does not exist, produce zero bytes. Any failed memory access ends the transfer with an error status.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset, busy is low, no memory request is raised and the item offset is 0.
- R2: A start pulse reads the descriptor as 16 single-byte reads at the descriptor address plus 0 to 15, in ascending order. The descriptor is big-endian. Bytes 0-3 form the control word, bytes 4-7 the length, and bytes 8-15 the 64-bit target address, each with its most significant byte first.
- R3: Control bit 3 (value 0x08) loads the item key from control bits 31:16. Bit 1 (0x02) selects read mode and bit 2 (0x04) selects skip mode. Read wins when both are set. When neither is set, no data write happens and the transfer still completes.
- R4: In read mode the engine issues one single-byte write per byte, to target, target+1, and so on. Each byte is the item byte at the current offset, and the offset then advances by one.
- R5: A byte that would come from the all-ones key (0xFFFF), from an absent item, or from an offset at or beyond the item length is written as 0x00. In that case the offset does not move.
- R6: Skip mode issues no data writes. The offset advances by the smaller of the length and the bytes left in the item.
- R7: Without the select bit, a transfer continues from the offset left by the previous one. A select sets the offset to 0, and this holds for every key, including invalid and absent ones.
- R8: Key bit 15 drives item_bank and key bits 14:0 drive item_index.
- R9: An error response on a data write ends the loop after that write. Bytes already written keep their offset advance. Status 0x00000001 is then written.
- R10: An error response on a descriptor read stops the fetch at once. No key is loaded, no data write follows, and status 0x00000001 is written.
- R11: Status goes out as four single-byte writes to the descriptor address plus 0 to 3, most significant byte first. The value is 0x00000000 on success.
- R12: busy rises in the cycle after an accepted start and falls only after the last status write is acknowledged. Start pulses that arrive while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the descriptor at desc_addr |
| desc_addr | input | ADDR_W | Address of the 16-byte descriptor |
| busy | output | 1 | High while a transfer is in progress |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_err | input | 1 | Error response, valid together with mem_ack |
| mem_rdata | input | 8 | Read byte, valid together with mem_ack |
| item_bank | output | 1 | Bank selected by the current key |
| item_index | output | KEY_W-1 | Index within the bank |
| item_offset | output | LEN_W | Current byte offset in the item |
| item_present | input | 1 | Item exists in the store |
| item_length | input | LEN_W | Item length in bytes |
| item_byte | input | 8 | Item byte at item_offset |

## Verification
The engine is exercised with these descriptor patterns:
- Read mode is run inside one item, across the item's end, and entirely past it. Together these separate real item data, zero fill, and a frozen offset.
- Skip mode is run with a count inside the item and with one past its end. This exposes an offset that grows without limit.
- Control words with both mode bits set and with neither set distinguish the read-over-skip priority from the no-transfer case.
- Error responses are injected on a data write and on a descriptor read, to separate early loop exit from a fetch abort.
- A start pulse arrives in the middle of a run, and one run uses a memory that stalls every other cycle, to expose dropped or duplicated bytes.

// File: rtl/cfgdma_pkg.sv
// Shared constants and types for the configuration item DMA engine.
// Assumes a 16-byte descriptor: control word, length word, 64-bit target.
package cfgdma_pkg;
    localparam int CTL_W      = 32;
    localparam int BIT_READ   = 1;
    localparam int BIT_SKIP   = 2;
    localparam int BIT_SELECT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_MOVE,
        ST_STATUS
    } state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_SKIP
    } op_e;
endpackage

// File: rtl/cfgdma_desc.sv
// Descriptor collector: shifts in descriptor bytes most significant first
// and decodes the control word. Assumes bytes arrive in address order.
module cfgdma_desc #(
    parameter int LEN_W  = 32,
    parameter int ADDR_W = 64,
    parameter int KEY_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push,
    input  logic [7:0]           byte_in,
    output logic [LEN_W-1:0]     len,
    output logic [ADDR_W-1:0]    tgt,
    output cfgdma_pkg::op_e      op,
    output logic                 sel_en,
    output logic [KEY_W-1:0]     sel_key
);
    import cfgdma_pkg::*;

    localparam int SR_W = CTL_W + LEN_W + ADDR_W;

    logic [SR_W-1:0]  sr;
    logic [CTL_W-1:0] ctl;

    // Shift register holding the big-endian descriptor image.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sr <= '0;
        else if (push)     sr <= {sr[SR_W-9:0], byte_in};
    end

    assign ctl = sr[SR_W-1 -: CTL_W];
    assign len = sr[ADDR_W +: LEN_W];
    assign tgt = sr[ADDR_W-1:0];

    // Control decode: read has priority over skip.
    always_comb begin
        if (ctl[BIT_READ])      op = OP_READ;
        else if (ctl[BIT_SKIP]) op = OP_SKIP;
        else                    op = OP_NONE;
        sel_en  = ctl[BIT_SELECT];
        sel_key = ctl[CTL_W-1 -: KEY_W];
    end
endmodule

// File: rtl/cfgdma_cursor.sv
// Item cursor: current key and byte offset. The offset survives between
// transfers and restarts at zero on every key load. The all-ones key
// means that no item is selected.
module cfgdma_cursor #(
    parameter int KEY_W = 16,
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] key_in,
    input  logic             adv,
    output logic             key_valid,
    output logic             bank,
    output logic [KEY_W-2:0] idx,
    output logic [OFF_W-1:0] off
);
    logic [KEY_W-1:0] key;

    // Key and offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key <= '1;
            off <= '0;
        end else if (load) begin
            key <= key_in;
            off <= '0;
        end else if (adv) begin
            off <= off + 1'b1;
        end
    end

    assign key_valid = (key != '1);
    assign bank      = key[KEY_W-1];
    assign idx       = key[KEY_W-2:0];
endmodule

// File: rtl/cfg_dma_engine.sv
// Descriptor-steered configuration item DMA engine.
// Fetches a descriptor, applies item select, runs a byte-per-beat
// read, skip or zero-fill loop, then writes a big-endian status word.
// Assumes the memory holds mem_ack low until it accepts the request.
module cfg_dma_engine #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32,
    parameter int KEY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              item_bank,
    output logic [KEY_W-2:0]  item_index,
    output logic [LEN_W-1:0]  item_offset,
    input  logic              item_present,
    input  logic [LEN_W-1:0]  item_length,
    input  logic [7:0]        item_byte
);
    import cfgdma_pkg::*;

    localparam int DESC_BYTES = (CTL_W + LEN_W + ADDR_W) / 8;
    localparam int CNT_W      = $clog2(DESC_BYTES);
    localparam int STAT_LAST  = CTL_W / 8 - 1;

    state_e            st;
    op_e               op_r;
    op_e               dec_op;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  remain;
    logic [ADDR_W-1:0] tgt_r;
    logic              err_r;
    logic              desc_clr, desc_push;
    logic [LEN_W-1:0]  dec_len;
    logic [ADDR_W-1:0] dec_tgt;
    logic              dec_sel;
    logic [KEY_W-1:0]  dec_key;
    logic              cur_load, cur_adv, key_valid, in_item;

    cfgdma_desc #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_desc (
        .clk(clk), .rst_n(rst_n), .clr(desc_clr), .push(desc_push),
        .byte_in(mem_rdata), .len(dec_len), .tgt(dec_tgt), .op(dec_op),
        .sel_en(dec_sel), .sel_key(dec_key)
    );

    cfgdma_cursor #(.KEY_W(KEY_W), .OFF_W(LEN_W)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(cur_load), .key_in(dec_key),
        .adv(cur_adv), .key_valid(key_valid), .bank(item_bank),
        .idx(item_index), .off(item_offset)
    );

    assign busy     = (st != ST_IDLE);
    assign desc_clr = (st == ST_IDLE) && start;
    assign cur_load = (st == ST_DECODE) && dec_sel;
    assign in_item  = key_valid && item_present && (item_offset < item_length);

    // Memory request and cursor-advance decode for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base + ADDR_W'(cnt);
        mem_wdata = 8'h00;
        desc_push = 1'b0;
        cur_adv   = 1'b0;
        case (st)
            ST_FETCH: begin
                mem_req   = 1'b1;
                desc_push = mem_ack && !mem_err;
            end
            ST_MOVE: begin
                if (remain != '0) begin
                    if (op_r == OP_READ) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = tgt_r;
                        mem_wdata = in_item ? item_byte : 8'h00;
                        cur_adv   = mem_ack && !mem_err && in_item;
                    end else begin
                        cur_adv = in_item;
                    end
                end
            end
            ST_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = (cnt == CNT_W'(STAT_LAST)) ? {7'd0, err_r} : 8'h00;
            end
            default: ;
        endcase
    end

    // Sequencer: fetch, decode, byte loop, status write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            op_r   <= OP_NONE;
            base   <= '0;
            cnt    <= '0;
            remain <= '0;
            tgt_r  <= '0;
            err_r  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    base  <= desc_addr;
                    cnt   <= '0;
                    err_r <= 1'b0;
                    st    <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err) begin
                        err_r <= 1'b1;
                        cnt   <= '0;
                        st    <= ST_STATUS;
                    end else if (cnt == CNT_W'(DESC_BYTES - 1)) begin
                        cnt <= '0;
                        st  <= ST_DECODE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DECODE: begin
                    op_r   <= dec_op;
                    remain <= (dec_op == OP_NONE) ? '0 : dec_len;
                    tgt_r  <= dec_tgt;
                    st     <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (remain == '0) begin
                        cnt <= '0;
                        st  <= ST_STATUS;
                    end else if (op_r != OP_READ) begin
                        remain <= remain - 1'b1;
                        tgt_r  <= tgt_r + 1'b1;
                    end else if (mem_ack) begin
                        if (mem_err) begin
                            err_r <= 1'b1;
                            cnt   <= '0;
                            st    <= ST_STATUS;
                        end else begin
                            remain <= remain - 1'b1;
                            tgt_r  <= tgt_r + 1'b1;
                        end
                    end
                end
                ST_STATUS: if (mem_ack) begin
                    if (cnt == CNT_W'(STAT_LAST)) st <= ST_IDLE;
                    else                          cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgdma_chk.sv
// Protocol checker for cfg_dma_engine, attached through bind.
// Observes only the engine's ports.
module cfgdma_chk #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [LEN_W-1:0]  item_offset
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R12
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_req && mem_we && mem_ack));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7
    off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(item_offset) |-> (item_offset == $past(item_offset) + 1'b1 || item_offset == '0));
endmodule

bind cfg_dma_engine cfgdma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .item_offset(item_offset)
);

// File: tb/tb_cfg_dma_engine.sv
// Bench: behavioural memory and item store plus a transaction-level model.
// The expected read and write streams are queued before each run and
// compared against every accepted memory beat.
module tb_cfg_dma_engine;
    localparam int ADDR_W = 64;
    localparam int LEN_W  = 32;
    localparam int KEY_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic busy, mem_req, mem_we, mem_ack, mem_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, item_byte;
    logic item_bank, item_present;
    logic [KEY_W-2:0] item_index;
    logic [LEN_W-1:0] item_offset, item_length;

    always #2 clk = ~clk;

    cfg_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .KEY_W(KEY_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .item_bank(item_bank), .item_index(item_index),
        .item_offset(item_offset), .item_present(item_present),
        .item_length(item_length), .item_byte(item_byte)
    );

    // Memory model.
    logic [7:0] mem [0:4095];
    logic [ADDR_W-1:0] err_addr = '0;
    logic err_on = 1'b0, stall_mode = 1'b0, stall_ph = 1'b0;
    assign mem_ack   = mem_req && (!stall_mode || stall_ph);
    assign mem_err   = err_on && (mem_addr == err_addr);
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) stall_ph <= ~stall_ph;
    always @(posedge clk)
        if (mem_req && mem_ack && mem_we && !mem_err) mem[mem_addr[11:0]] <= mem_wdata;

    // Item store model: indices 0..3 exist in both banks.
    function automatic logic [31:0] f_len(logic b, int idx);
        return 32'(idx * 3 + 3 + (b ? 2 : 0));
    endfunction
    function automatic logic [7:0] f_byte(logic b, int idx, int off);
        return 8'(idx * 16 + off * 7 + (b ? 128 : 0));
    endfunction
    assign item_present = (item_index < 4);
    assign item_length  = item_present ? f_len(item_bank, int'(item_index)) : 32'd0;
    assign item_byte    = f_byte(item_bank, int'(item_index), int'(item_offset));

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    logic [15:0] m_key = 16'hFFFF;
    int m_off = 0;
    logic [ADDR_W+7:0] exp_w[$];
    logic [ADDR_W-1:0] exp_r[$];

    task automatic chk(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every accepted beat with the head of the expected stream.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                if (exp_w.size() == 0) chk(0, cur_req, "unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [ADDR_W+7:0] e;
                    e = exp_w.pop_front();
                    chk({mem_addr, mem_wdata} == e, cur_req, "write addr/data", {mem_addr, mem_wdata}, e);
                end
            end else begin
                if (exp_r.size() == 0) chk(0, cur_req, "unexpected read", mem_addr, 0);
                else begin
                    logic [ADDR_W-1:0] e;
                    e = exp_r.pop_front();
                    chk(mem_addr == e, cur_req, "read addr", mem_addr, e);
                end
            end
        end
    end

    // Build the expected streams from the requirements.
    task automatic model(logic [ADDR_W-1:0] d, logic [31:0] ctl, int len, logic [ADDR_W-1:0] tgt);
        bit fail = 0;
        for (int i = 0; i < 16; i++) begin
            exp_r.push_back(d + ADDR_W'(i));
            if (err_on && d + ADDR_W'(i) == err_addr) begin fail = 1; break; end
        end
        if (!fail) begin
            bit rd, sk;
            if (ctl[3]) begin m_key = ctl[31:16]; m_off = 0; end
            rd = ctl[1];
            sk = !rd && ctl[2];
            if (rd || sk) begin
                for (int i = 0; i < len; i++) begin
                    logic [ADDR_W-1:0] a;
                    logic b;
                    int idx;
                    bit inr;
                    logic [7:0] dat;
                    a   = tgt + ADDR_W'(i);
                    b   = m_key[15];
                    idx = int'(m_key[14:0]);
                    inr = (m_key != 16'hFFFF) && idx < 4 && m_off < int'(f_len(b, idx));
                    dat = inr ? f_byte(b, idx, m_off) : 8'h00;
                    if (rd) begin
                        exp_w.push_back({a, dat});
                        if (err_on && a == err_addr) begin fail = 1; break; end
                    end
                    if (inr) m_off++;
                end
            end
        end
        for (int j = 0; j < 4; j++)
            exp_w.push_back({d + ADDR_W'(j), (j == 3) ? {7'd0, fail} : 8'h00});
    endtask

    task automatic run(logic [ADDR_W-1:0] d, logic [31:0] ctl, int len,
                       logic [ADDR_W-1:0] tgt, bit extra, string req);
        int n = 0;
        cur_req = req;
        for (int k = 0; k < 4; k++) begin
            mem[d[11:0] + 12'(k)]     = ctl[31 - 8*k -: 8];
            mem[d[11:0] + 12'(4 + k)] = 8'(len >> (24 - 8*k));
        end
        for (int k = 0; k < 8; k++) mem[d[11:0] + 12'(8 + k)] = tgt[63 - 8*k -: 8];
        model(d, ctl, len, tgt);
        @(negedge clk); start = 1'b1; desc_addr = d;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R12", "busy after start", busy, 1);
        if (extra) begin
            repeat (3) @(negedge clk);
            desc_addr = d + 64; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (busy && n < 3000) begin @(negedge clk); n++; end
        chk(n < 3000, req, "run completes", n, 3000);
        chk(exp_w.size() == 0, req, "writes outstanding", exp_w.size(), 0);
        chk(exp_r.size() == 0, req, "reads outstanding", exp_r.size(), 0);
        chk(item_offset == LEN_W'(m_off), req, "item offset", item_offset, m_off);
        exp_w.delete(); exp_r.delete();
    endtask

    localparam logic [ADDR_W-1:0] D0 = 64'h0000_0000_0000_0100;
    localparam logic [ADDR_W-1:0] T0 = 64'h0000_0001_0000_0400;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy in reset", busy, 0);
        chk(mem_req == 0, "R1", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(item_offset == 0, "R1", "offset after reset", item_offset, 0);
        // R2 R4 R8 read inside item, 64-bit target
        run(D0, 32'h0002_000A, 5, T0, 0, "R4");
        chk(item_bank == 0 && item_index == 2, "R8", "bank/index key 0x0002", {item_bank, item_index}, 2);
        // R5 R7 continue past end of item
        run(D0 + 32, 32'h0000_0002, 8, T0 + 16, 0, "R7");
        // R6 R8 skip inside bank-1 item, then read without select
        run(D0, 32'h8001_000C, 3, T0, 0, "R6");
        chk(item_bank == 1 && item_index == 1, "R8", "bank/index key 0x8001", {item_bank, item_index}, 16'h8001);
        run(D0, 32'h0000_0002, 4, T0 + 32, 0, "R8");
        // R6 skip beyond item end
        run(D0, 32'h0000_0004, 10, T0, 0, "R6");
        // R3 neither mode bit: select applied, no data
        run(D0 + 48, 32'h0000_0008, 6, T0, 0, "R3");
        // R3 both mode bits: read wins
        run(D0, 32'h0001_000E, 4, T0 + 64, 0, "R3");
        // R5 invalid key and absent item
        run(D0, 32'hFFFF_000A, 4, T0, 0, "R5");
        run(D0, 32'h0005_000A, 3, T0 + 8, 0, "R5");
        // R9 write error
        err_on = 1'b1; err_addr = T0 + 2;
        run(D0, 32'h0003_000A, 6, T0, 0, "R9");
        // R10 descriptor read error
        err_addr = D0 + 64 + 5;
        run(D0 + 64, 32'h0002_000A, 4, T0, 0, "R10");
        err_on = 1'b0;
        // R12 start while busy is ignored
        run(D0, 32'h0000_000A, 5, T0, 1, "R12");
        // R11 stalling memory, long read across item end
        stall_mode = 1'b1;
        run(D0 + 128, 32'h8003_000A, 20, T0 + 128, 0, "R11");
        stall_mode = 1'b0;
        chk(mem[D0[11:0] + 128 + 3] == 8'h00, "R11", "status byte", mem[D0[11:0] + 131], 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog %s: actual=timeout expected=done", cur_req);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule